// File: doc/BRIEF.md
# Sampled Position/Velocity Readout Port

This block keeps a frozen copy of a 12-bit unsigned shaft position and a 12-bit two's-complement velocity. A falling edge on the sample strobe takes that copy from the live integrator values. A host then reads either word. It can use a 12-bit bus with per-bit output enables, or a three-wire serial link. In the serial link the read strobe frames the transfer, a host-driven serial clock advances it, and the top data bit carries the serial data.

The chip-select, read-strobe, serial-clock and sample-strobe pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and all edges are detected on the synchronised copies. The falling edge of the read strobe, with chip select low, loads a 16-bit frame into an output register. The frame holds the selected word, the source bit, the two fault flags and an odd-parity bit. In serial mode the frame is shifted out MSB first.

Top module: `readout_port`

## Requirements
- R1: A high-to-low transition of `sample_i` copies `pos_i` and `vel_i` into holding registers. Between such transitions the held values do not change. After reset both held values are zero.
- R2: `rdvel_i` high selects the held position and low selects the held velocity. It is sampled when the read strobe falls.
- R3: `soe_i` high selects parallel mode: all 12 enables in `data_oe_o` are high during a read. `soe_i` low selects serial mode: only bit 11 is enabled (`data_oe_o` = 12'h800), bit 11 carries serial data, and bits 10..0 are high impedance.
- R4: `data_oe_o` is nonzero only while both `cs_ni` and `rd_ni` are low. It returns to zero after `rd_ni` or `cs_ni` rises.
- R5: The 16-bit frame is {word[11:0], rdvel, dos, lot, parity}. Frame bit 15 is word bit 11, bit 3 is the source bit (1 = position), bit 2 is `dos_i`, bit 1 is `lot_i` and bit 0 is parity. The fault flags are taken when the read strobe falls. In parallel mode `data_o` shows frame bits 15..4.
- R6: Parity makes the count of ones in the 16-bit frame odd.
- R7: Frame bit 15 is on `data_o[11]` once the read strobe falls, before any serial-clock edge. Each rising edge of `sclk_i` with the read strobe low moves the next bit out. After 15 edges bit 0 is shown, and further edges shift out zeros.
- R8: A new sample strobe during a read does not change the frame already loaded. In parallel mode serial-clock edges do not change it either.
- R9: Every pin edge takes effect at the ports within 4 system clocks, through a two-flop synchroniser followed by edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample strobe; falling edge captures |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe / serial frame sync, active low |
| rdvel_i | input | 1 | Source select: 1 position, 0 velocity |
| soe_i | input | 1 | Mode: 1 parallel, 0 serial |
| sclk_i | input | 1 | Serial clock |
| pos_i | input | 12 | Live position |
| vel_i | input | 12 | Live velocity, two's complement |
| dos_i | input | 1 | Signal-degradation flag |
| lot_i | input | 1 | Tracking-loss flag |
| data_o | output | 12 | Parallel data; bit 11 is serial data in serial mode |
| data_oe_o | output | 12 | Per-bit output enable (0 = high impedance) |

## Verification
A wrong held value appears as a wrong word at the next read. It shows in the first parallel read or in the first 12 serial bits after capture. A corrupted frame register breaks the odd count of ones, and the parity check catches this on the same read. A fault in shift control shifts a bit too many or too few times. That shows within one serial-clock period as a misplaced bit or as missing zero fill. An enable fault shows 4 clocks after a strobe edge as a nonzero or wrong `data_oe_o`.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int unsigned TAIL_W = 4; // rdvel, dos, lot, parity

  function automatic logic odd_par(input logic [31:0] v, input int unsigned n);
    logic p;
    p = 1'b1;
    for (int i = 0; i < 32; i++) if (i < n) p ^= v[i];
    return p;
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= rst_val_i;
      sync_q <= rst_val_i;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/snapshot_regs.sv
module snapshot_regs #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] pos_i,
  input  logic [DATA_W-1:0] vel_i,
  input  logic              sel_pos_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] pos_q, vel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      vel_q <= '0;
    end else if (cap_i) begin
      pos_q <= pos_i;
      vel_q <= vel_i;
    end
  end
  assign word_o = sel_pos_i ? pos_q : vel_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(pos_q) && $stable(vel_q))); // R1
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import rdo_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned FRAME_W = DATA_W + TAIL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DATA_W-1:0]  word_i,
  input  logic               sel_pos_i,
  input  logic               dos_i,
  input  logic               lot_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-2:0] body;

  assign body = {word_i, sel_pos_i, dos_i, lot_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= '0;
    else if (load_i)   frame_q <= {body, odd_par(32'(body), FRAME_W - 1)};
    else if (shift_i)  frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
  end
  assign frame_o = frame_q;

  AST_PARITY_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ($countones(frame_q) % 2 == 1)); // R6
  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> !frame_q[0]); // R7
  AST_FRAME_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(frame_q)); // R8
endmodule

// File: rtl/readout_port.sv
module readout_port
  import rdo_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              rdvel_i,
  input  logic              soe_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] pos_i,
  input  logic [DATA_W-1:0] vel_i,
  input  logic              dos_i,
  input  logic              lot_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int unsigned FRAME_W = DATA_W + TAIL_W;
  localparam int unsigned NSYNC   = 4;

  // sync order: {sclk, rd, cs, sample}
  logic [NSYNC-1:0] pins_s, pins_d;
  logic sample_s, cs_s, rd_s, sclk_s;

  sync_2ff #(.W(NSYNC)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({sclk_i, rd_ni, cs_ni, sample_i}),
    .rst_val_i(4'b0111),
    .q_o      (pins_s)
  );
  assign {sclk_s, rd_s, cs_s, sample_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_d <= 4'b0111;
    else         pins_d <= pins_s;
  end

  logic sample_fall, rd_fall, sclk_rise, drive, load, shift;
  assign sample_fall = pins_d[0] & ~sample_s;
  assign rd_fall     = pins_d[2] & ~rd_s;
  assign sclk_rise   = ~pins_d[3] & sclk_s;
  assign drive       = ~cs_s & ~rd_s;
  assign load        = rd_fall & ~cs_s;
  assign shift       = sclk_rise & drive & ~soe_i & ~rd_fall;

  logic [DATA_W-1:0]  held_word;
  logic [FRAME_W-1:0] frame;

  snapshot_regs #(.DATA_W(DATA_W)) u_snap (
    .clk_i, .rst_ni,
    .cap_i    (sample_fall),
    .pos_i, .vel_i,
    .sel_pos_i(rdvel_i),
    .word_o   (held_word)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i   (load),
    .shift_i  (shift),
    .word_i   (held_word),
    .sel_pos_i(rdvel_i),
    .dos_i, .lot_i,
    .frame_o  (frame)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    assign data_o[i] = frame[i + TAIL_W];
    if (i == DATA_W - 1) begin : g_shared
      assign data_oe_o[i] = drive;          // parallel MSB or serial out
    end else begin : g_par
      assign data_oe_o[i] = drive & soe_i;  // high-Z in serial mode
    end
  end

  AST_HIZ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_s || cs_s) |-> (data_oe_o == '0)); // R4
  AST_SERIAL_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soe_i && !rd_s && !cs_s) |-> (data_oe_o == {1'b1, {(DATA_W-1){1'b0}}})); // R3
endmodule

// File: tb/sim_readout_port.sv
module sim_readout_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample = 1'b1, cs_n = 1'b1, rd_n = 1'b1, rdvel = 1'b1, soe = 1'b1, sclk = 1'b0;
  logic [11:0] pos = '0, vel = '0;
  logic dos = 1'b1, lot = 1'b1;
  logic [11:0] data, oe;
  int tests = 0, fails = 0;
  logic [11:0] hp = '0, hv = '0;

  always #10 clk = ~clk;

  readout_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .cs_ni(cs_n), .rd_ni(rd_n),
    .rdvel_i(rdvel), .soe_i(soe), .sclk_i(sclk), .pos_i(pos), .vel_i(vel),
    .dos_i(dos), .lot_i(lot), .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_frame(input logic [11:0] w, input logic s, d, l);
    logic [14:0] b;
    b = {w, s, d, l};
    return {b, ~^b};
  endfunction

  task automatic do_sample(input logic [11:0] p, input logic [11:0] v);
    pos = p; vel = v;
    sample = 1'b0; wclk(4);
    pos = ~p; vel = ~v; // live values move on after capture
    sample = 1'b1; wclk(4);
    hp = p; hv = v;
  endtask

  task automatic par_read(input logic sel);
    logic [15:0] f;
    rdvel = sel; soe = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wclk(4);
    f = exp_frame(sel ? hp : hv, sel, dos, lot);
    chk("R3 par oe", 32'(oe), 32'hfff);
    chk("R2 R5 par data", 32'(data), 32'(f[15:4]));
    sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
    chk("R8 sclk ignored in parallel", 32'(data), 32'(f[15:4]));
    rd_n = 1'b1; wclk(4);
    chk("R4 oe off after rd", 32'(oe), 32'h0);
    cs_n = 1'b1;
  endtask

  task automatic ser_read(input logic sel, input bit resample, input logic [11:0] np);
    logic [15:0] f, got;
    rdvel = sel; soe = 1'b0; cs_n = 1'b0; rd_n = 1'b0; wclk(4);
    f = exp_frame(sel ? hp : hv, sel, dos, lot);
    chk("R3 ser oe", 32'(oe), 32'h800);
    got[15] = data[11];
    chk("R7 msb before sclk", 32'(data[11]), 32'(f[15]));
    if (resample) do_sample(np, ~np); // R8
    for (int i = 14; i >= 0; i--) begin
      sclk = 1'b1; wclk(4); got[i] = data[11]; sclk = 1'b0; wclk(4);
    end
    chk("R5 R7 R8 serial frame", 32'(got), 32'(f));
    chk("R6 odd parity", 32'($countones(got) % 2), 32'd1);
    for (int i = 0; i < 2; i++) begin
      sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
      chk("R7 zero fill", 32'(data[11]), 32'd0);
    end
    rd_n = 1'b1; wclk(4);
    chk("R4 R9 oe off", 32'(oe), 32'h0);
    cs_n = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1205));
    wclk(3); rst_n = 1'b1; wclk(4);
    chk("R4 reset oe", 32'(oe), 32'h0);
    // R1 reset holds zero
    dos = 1'b0; lot = 1'b1;
    par_read(1'b1);
    par_read(1'b0);
    // R4 rd low but cs high
    cs_n = 1'b1; rd_n = 1'b0; wclk(4);
    chk("R4 cs high no drive", 32'(oe), 32'h0);
    rd_n = 1'b1; wclk(4);
    // directed corners
    do_sample(12'hfff, 12'h800);
    dos = 1'b1; lot = 1'b1;
    ser_read(1'b1, 0, '0);
    ser_read(1'b0, 0, '0);
    do_sample(12'h000, 12'h7ff);
    dos = 1'b0; lot = 1'b0;
    ser_read(1'b1, 1, 12'habc); // R8 new sample mid-read
    par_read(1'b1); // R1 new capture now visible
    // R1 no sample edge: live changes ignored
    pos = 12'h123; vel = 12'h456; wclk(4);
    par_read(1'b0);
    for (int n = 0; n < 30; n++) begin
      logic [11:0] rp, rv;
      rp = 12'($urandom); rv = 12'($urandom);
      do_sample(rp, rv);
      dos = 1'($urandom); lot = 1'($urandom);
      if ($urandom % 2) ser_read(1'($urandom), 1'($urandom), 12'($urandom));
      else              par_read(1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule